// File: doc/BRIEF.md
# Two-Way Write-Back Cache Controller

This block is a two-way set-associative, write-back, write-allocate cache. It sits between a 32-bit word-access CPU port and a word-wide memory port. Each way has 128 lines of eight 32-bit words, so one way covers 4 kB. When a set has a free way, a new line takes it. When both ways are full, a single recency bit per set picks the way to replace. A dirty line is streamed back to memory before its slot is refilled.

Every CPU request carries an instruction/data flag. Two plain enable pins decide which of the two classes goes through the cache. A request whose class is not enabled becomes a single-word memory transaction and leaves all cache state alone.

Both data ports use valid/ready handshakes:

- **CPU port.** The requester raises `cpu_valid` and holds the address, write flag, class flag and write data unchanged until `cpu_ready` is high at a clock edge. Read data is valid in that same cycle.
- **Memory port.** The cache holds `mem_valid`, `mem_addr`, `mem_we` and `mem_wdata` steady until `mem_ready`. One word moves on each edge where both are high. For a read, `mem_rdata` must be valid in the cycle `mem_ready` is high.
- **Enables.** The enable pins may change only while no request is pending.

Top module: `cache2w_top`

## Requirements
- R1: Byte address bits [4:2] select the word in a line, bits [11:5] select the set, and bits [31:12] form the stored tag. Words 8k to 8k+7 of a 4 kB region share set k.
- R2: A cached read whose line is present in either way raises `cpu_ready` in the cycle the request is presented, with the word on `cpu_rdata`, and causes no memory transaction.
- R3: On a cached miss, the line goes into way 0 if way 0 of the set is invalid. Otherwise it goes into way 1 if way 1 is invalid.
- R4: When both ways of the set are valid, the way not used by the most recent cached access to that set is replaced. Every cached access, hit or miss, makes its way the most recent.
- R5: If the chosen victim is dirty, its eight words are written to memory first, at word addresses 0 to 7 of the victim line in ascending order, before any fill beat.
- R6: A fill reads the eight words of the missing line in ascending order from word 0. `cpu_ready` rises in the cycle after the last fill beat, carrying the requested word.
- R7: A cached write hit updates the cached word and marks the line dirty, with no memory transaction. A cached write miss first fills the line, then merges the word and marks the line dirty.
- R8: With `cpu_instr`=1 the request is cached only if `en_instr`=1; with `cpu_instr`=0 only if `en_data`=1. An uncached request issues exactly one memory beat with the CPU's address, write flag and data. `cpu_ready` is high in the cycle that beat completes, and `cpu_rdata` equals `mem_rdata`.
- R9: An uncached request changes no tag, valid, dirty or recency state. A line present before it is still a hit afterwards, and a line absent before it is still a miss.
- R10: While `rst` is high, `cpu_ready` and `mem_valid` are low. After reset every line is invalid and clean, and every set's recency bit is cleared.
- R11: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr`, `mem_we` and `mem_wdata` hold their values into the next cycle.
- R12: `cpu_ready` is never high while a writeback or fill beat of the current request is still outstanding. The requester holds `cpu_valid` and `cpu_addr` until `cpu_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en_data | input | 1 | Enable caching of data-class requests |
| en_instr | input | 1 | Enable caching of instruction-class requests |
| cpu_valid | input | 1 | CPU request valid |
| cpu_ready | output | 1 | CPU request accepted and completed this cycle |
| cpu_instr | input | 1 | 1: instruction-class request, 0: data-class |
| cpu_we | input | 1 | 1: write, 0: read |
| cpu_addr | input | 32 | Byte address, word aligned |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, valid with `cpu_ready` |
| mem_valid | output | 1 | Memory beat request |
| mem_ready | input | 1 | Memory beat accepted this cycle |
| mem_we | output | 1 | 1: write beat, 0: read beat |
| mem_addr | output | 32 | Beat byte address |
| mem_wdata | output | 32 | Write beat data |
| mem_rdata | input | 32 | Read beat data, valid with `mem_ready` |

## Verification
Timing of each result, counted from when the request is presented:

- **Cached hit:** completes in the cycle the request is presented, with no memory beats.
- **Uncached request:** completes in the same cycle as its single memory beat.
- **Miss:** the first memory beat can appear one cycle after the request at the earliest, because the miss is registered first. `cpu_ready` is due exactly one cycle after the last fill beat.

Inputs are driven at the falling edge. Memory-side beats are compared against a queue of expected beats, predicted by a behavioural model of tags, recency and dirty bits, a little before the next rising edge. CPU completion is sampled just after that. The bench therefore flags both a late `cpu_ready` and a `cpu_ready` that arrives while expected beats remain. `mem_ready` is withheld on a fixed pattern to exercise stalls.

// File: rtl/cache2w_pkg.sv
`timescale 1ns/1ps
package cache2w_pkg;
  localparam int ADDR_W     = 32;
  localparam int DATA_W     = 32;
  localparam int LINE_WORDS = 8;
  localparam int NUM_SETS   = 128;
  localparam int OFF_W      = $clog2(LINE_WORDS);
  localparam int IDX_W      = $clog2(NUM_SETS);
  localparam int BYTE_W     = $clog2(DATA_W / 8);
  localparam int TAG_W      = ADDR_W - IDX_W - OFF_W - BYTE_W;
  localparam int DEPTH      = NUM_SETS * LINE_WORDS;

  typedef enum logic [1:0] {ST_IDLE, ST_WB, ST_FILL} st_e;
endpackage

// File: rtl/cache2w_tags.sv
`timescale 1ns/1ps
// Tag, valid, dirty and recency storage with hit and victim selection.
module cache2w_tags
  import cache2w_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] idx,
  input  logic [TAG_W-1:0] tag,
  output logic             hit,
  output logic             hit_way,
  output logic             vic_way,
  output logic             vic_dirty,
  output logic [TAG_W-1:0] vic_tag,
  input  logic             touch,
  input  logic             touch_way,
  input  logic             touch_wr,
  input  logic             fill,
  input  logic             fill_way
);
  logic [1:0]            way_hit;
  logic [1:0]            way_val;
  logic [1:0]            way_dty;
  logic [1:0][TAG_W-1:0] way_tag;
  logic [NUM_SETS-1:0]   evict_q;  // per set: way to replace next

  for (genvar w = 0; w < 2; w++) begin : g_way
    logic [NUM_SETS-1:0] val_q;
    logic [NUM_SETS-1:0] dty_q;
    logic [TAG_W-1:0]    tag_q [NUM_SETS];

    assign way_val[w] = val_q[idx];
    assign way_dty[w] = dty_q[idx];
    assign way_tag[w] = tag_q[idx];
    assign way_hit[w] = val_q[idx] && (tag_q[idx] == tag);

    always_ff @(posedge clk) begin
      if (rst) begin
        val_q <= '0;
        dty_q <= '0;
      end else if (fill && fill_way == 1'(w)) begin
        val_q[idx] <= 1'b1;
        dty_q[idx] <= 1'b0;
      end else if (touch && touch_wr && touch_way == 1'(w)) begin
        dty_q[idx] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (fill && fill_way == 1'(w)) tag_q[idx] <= tag;
    end
  end

  assign hit       = |way_hit;
  assign hit_way   = way_hit[1];
  assign vic_way   = !way_val[0] ? 1'b0 : (!way_val[1] ? 1'b1 : evict_q[idx]);
  assign vic_dirty = way_val[vic_way] && way_dty[vic_way];
  assign vic_tag   = way_tag[vic_way];

  always_ff @(posedge clk) begin
    if (rst)        evict_q <= '0;
    else if (touch) evict_q[idx] <= ~touch_way;
  end
endmodule

// File: rtl/cache2w_data.sv
`timescale 1ns/1ps
// Line data for both ways: asynchronous read of both, one write port.
module cache2w_data
  import cache2w_pkg::*;
(
  input  logic                  clk,
  input  logic [IDX_W-1:0]      idx,
  input  logic [OFF_W-1:0]      off,
  output logic [1:0][DATA_W-1:0] rd,
  input  logic                  we,
  input  logic                  wway,
  input  logic [DATA_W-1:0]     wd
);
  logic [IDX_W+OFF_W-1:0] waddr;
  assign waddr = {idx, off};

  for (genvar w = 0; w < 2; w++) begin : g_way
    logic [DATA_W-1:0] mem_q [DEPTH];
    assign rd[w] = mem_q[waddr];
    always_ff @(posedge clk) begin
      if (we && wway == 1'(w)) mem_q[waddr] <= wd;
    end
  end
endmodule

// File: rtl/cache2w_ctrl.sv
`timescale 1ns/1ps
// Miss sequencer: optional writeback burst, then fill burst.
module cache2w_ctrl
  import cache2w_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             req_miss,
  input  logic             miss_way,
  input  logic             miss_dirty,
  input  logic [TAG_W-1:0] miss_tag,
  input  logic             mem_ready,
  output st_e              st,
  output logic [OFF_W-1:0] beat,
  output logic             way,
  output logic [TAG_W-1:0] wb_tag,
  output logic             fill_last
);
  localparam logic [OFF_W-1:0] LAST = OFF_W'(LINE_WORDS - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= ST_IDLE;
      beat <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (req_miss) begin
          way    <= miss_way;
          wb_tag <= miss_tag;
          beat   <= '0;
          st     <= miss_dirty ? ST_WB : ST_FILL;
        end
        ST_WB: if (mem_ready) begin
          beat <= beat + 1'b1;
          if (beat == LAST) st <= ST_FILL;
        end
        ST_FILL: if (mem_ready) begin
          beat <= beat + 1'b1;
          if (beat == LAST) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign fill_last = (st == ST_FILL) && mem_ready && (beat == LAST);
endmodule

// File: rtl/cache2w_top.sv
`timescale 1ns/1ps
module cache2w_top
  import cache2w_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              en_data,
  input  logic              en_instr,
  input  logic              cpu_valid,
  output logic              cpu_ready,
  input  logic              cpu_instr,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  logic [IDX_W-1:0]       idx;
  logic [OFF_W-1:0]       off;
  logic [TAG_W-1:0]       tag;
  logic                   act, cacheable, in_idle, hit_go, req_miss;
  logic                   lk_hit, lk_way, vic_way, vic_dirty;
  logic [TAG_W-1:0]       vic_tag, wb_tag;
  st_e                    st;
  logic [OFF_W-1:0]       beat, d_off;
  logic                   way_q, fill_last, d_we;
  logic [1:0][DATA_W-1:0] rd;

  assign idx       = cpu_addr[BYTE_W+OFF_W +: IDX_W];
  assign off       = cpu_addr[BYTE_W +: OFF_W];
  assign tag       = cpu_addr[ADDR_W-1 -: TAG_W];
  assign act       = cpu_valid && !rst;
  assign cacheable = cpu_instr ? en_instr : en_data;
  assign in_idle   = (st == ST_IDLE);
  assign hit_go    = in_idle && act && cacheable && lk_hit;
  assign req_miss  = in_idle && act && cacheable && !lk_hit;
  assign d_off     = in_idle ? off : beat;
  assign d_we      = (hit_go && cpu_we) || (st == ST_FILL && mem_ready);

  cache2w_tags u_tags (
    .clk(clk), .rst(rst), .idx(idx), .tag(tag),
    .hit(lk_hit), .hit_way(lk_way), .vic_way(vic_way), .vic_dirty(vic_dirty),
    .vic_tag(vic_tag), .touch(hit_go), .touch_way(lk_way), .touch_wr(cpu_we),
    .fill(fill_last), .fill_way(way_q)
  );

  cache2w_data u_data (
    .clk(clk), .idx(idx), .off(d_off), .rd(rd), .we(d_we),
    .wway(in_idle ? lk_way : way_q), .wd(in_idle ? cpu_wdata : mem_rdata)
  );

  cache2w_ctrl u_ctrl (
    .clk(clk), .rst(rst), .req_miss(req_miss), .miss_way(vic_way),
    .miss_dirty(vic_dirty), .miss_tag(vic_tag), .mem_ready(mem_ready),
    .st(st), .beat(beat), .way(way_q), .wb_tag(wb_tag), .fill_last(fill_last)
  );

  always_comb begin
    cpu_ready = 1'b0;
    cpu_rdata = rd[lk_way];
    mem_valid = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    if (!rst) begin
      unique case (st)
        ST_IDLE: begin
          if (act && !cacheable) begin
            mem_valid = 1'b1;
            mem_we    = cpu_we;
            mem_addr  = cpu_addr;
            mem_wdata = cpu_wdata;
            cpu_ready = mem_ready;
            cpu_rdata = mem_rdata;
          end else begin
            cpu_ready = hit_go;
          end
        end
        ST_WB: begin
          mem_valid = 1'b1;
          mem_we    = 1'b1;
          mem_addr  = {wb_tag, idx, beat, {BYTE_W{1'b0}}};
          mem_wdata = rd[way_q];
        end
        ST_FILL: begin
          mem_valid = 1'b1;
          mem_addr  = {tag, idx, beat, {BYTE_W{1'b0}}};
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cache2w_chk.sv
`timescale 1ns/1ps
module cache2w_chk
  import cache2w_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              cpu_valid,
  input logic              cpu_ready,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata
);
  // R11
  mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  // R6
  burst_step_chk: assert property (@(posedge clk) disable iff (rst)
    mem_valid && mem_ready && !cpu_ready && (mem_addr[BYTE_W +: OFF_W] != {OFF_W{1'b1}})
    |=> mem_valid && (mem_addr == $past(mem_addr) + ADDR_W'(DATA_W / 8)) && (mem_we == $past(mem_we)));

  // R8
  byp_ready_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_ready && mem_valid |-> mem_ready);

  // R12
  cpu_hold_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_valid && !cpu_ready |=> cpu_valid && $stable(cpu_addr));

  // R12
  ready_req_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |-> cpu_valid);

  // R10
  rst_quiet_chk: assert property (@(posedge clk)
    rst |-> !cpu_ready && !mem_valid);
endmodule

bind cache2w_top cache2w_chk u_chk (
  .clk(clk), .rst(rst), .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_addr(cpu_addr),
  .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata)
);

// File: tb/cache2w_top_tb.sv
`timescale 1ns/1ps
module cache2w_top_tb;
  logic        clk = 1'b0, rst = 1'b1;
  logic        en_data = 1'b1, en_instr = 1'b1;
  logic        cpu_valid = 1'b0, cpu_ready, cpu_instr = 1'b0, cpu_we = 1'b0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0, cpu_rdata;
  logic        mem_valid, mem_ready = 1'b0, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;

  int checks = 0, errors = 0;

  cache2w_top u_dut (
    .clk(clk), .rst(rst), .en_data(en_data), .en_instr(en_instr),
    .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_instr(cpu_instr), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always #10 clk = ~clk;  // 50 MHz

  // backing memory, keyed by word address
  logic [31:0] mem [logic [29:0]];
  function automatic logic [31:0] memrd(input logic [31:0] a);
    if (mem.exists(a[31:2])) return mem[a[31:2]];
    return (a * 32'h9E37_79B9) ^ 32'h5A5A_0F0F;
  endfunction

  // behavioural reference state
  logic [19:0] m_tag  [2][128];
  bit          m_val  [2][128];
  bit          m_dty  [2][128];
  bit          m_lru  [128];     // way to replace next
  logic [31:0] m_data [2][128][8];

  logic [31:0] qa[$], qd[$];
  bit          qw[$];
  string       cur_req = "R10";

  task automatic fail(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    errors++;
    $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
  endtask

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) fail(req, what, act, exp);
  endtask

  // memory side responder and beat checker
  int          rcnt = 0;
  bit          hold_pend = 0;
  logic [31:0] hold_addr;
  always begin
    @(negedge clk);
    rcnt++;
    mem_ready = !rst && (rcnt % 5 != 4) && (rcnt % 7 != 2);
    #1 mem_rdata = memrd(mem_addr);
    #1;
    if (!rst) begin
      if (hold_pend) begin  // R11
        checks++;
        if (!mem_valid || mem_addr !== hold_addr) fail("R11", "held beat address", mem_addr, hold_addr);
      end
      hold_pend = mem_valid && !mem_ready;
      hold_addr = mem_addr;
      if (mem_valid && mem_ready) begin
        checks++;
        if (qa.size() == 0) begin
          fail(cur_req, "unexpected memory beat", mem_addr, 32'hFFFF_FFFF);
        end else begin
          logic [31:0] ea, ed;
          bit ew;
          ea = qa.pop_front(); ed = qd.pop_front(); ew = qw.pop_front();
          if (mem_addr !== ea || mem_we !== ew) fail(cur_req, "beat address/we", {mem_addr[31:1], mem_we}, {ea[31:1], ew});
          else if (ew && mem_wdata !== ed) fail(cur_req, "beat write data", mem_wdata, ed);
        end
        if (mem_we) mem[mem_addr[31:2]] = mem_wdata;
      end
    end
  end

  task automatic access(input bit instr, input bit we, input logic [31:0] a, input logic [31:0] d, input string req);
    logic [31:0] exp, la;
    logic [6:0]  ix;
    logic [2:0]  of;
    logic [19:0] tg;
    bit cached, wasempty, late;
    int hw, v, cyc;
    ix = a[11:5]; of = a[4:2]; tg = a[31:12];  // R1
    cached = instr ? en_instr : en_data;
    cur_req = req;
    if (!cached) begin
      qa.push_back(a); qw.push_back(we); qd.push_back(d);
      exp = memrd(a);
    end else begin
      hw = -1;
      for (int w = 0; w < 2; w++) if (m_val[w][ix] && m_tag[w][ix] == tg) hw = w;
      if (hw < 0) begin
        v = !m_val[0][ix] ? 0 : (!m_val[1][ix] ? 1 : int'(m_lru[ix]));
        if (m_val[v][ix] && m_dty[v][ix])
          for (int k = 0; k < 8; k++) begin
            qa.push_back({m_tag[v][ix], ix, 3'(k), 2'b00}); qw.push_back(1'b1); qd.push_back(m_data[v][ix][k]);
          end
        for (int k = 0; k < 8; k++) begin
          la = {tg, ix, 3'(k), 2'b00};
          qa.push_back(la); qw.push_back(1'b0); qd.push_back('0);
          m_data[v][ix][k] = memrd(la);
        end
        m_val[v][ix] = 1; m_dty[v][ix] = 0; m_tag[v][ix] = tg;
        hw = v;
      end
      m_lru[ix] = (hw == 0);
      if (we) begin m_data[hw][ix][of] = d; m_dty[hw][ix] = 1; end
      exp = m_data[hw][ix][of];
    end
    wasempty = cached && qa.size() == 0;
    late = 0;
    cyc = 0;
    @(negedge clk);
    cpu_valid = 1; cpu_instr = instr; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    forever begin
      #3;
      if (cpu_ready) begin
        check("R12", "beats left at completion", qa.size(), 0);
        if (!we) check(req, "read data", cpu_rdata, exp);
        break;
      end
      if (wasempty && !late) begin
        late = 1;
        errors++; checks++;
        $display("FAIL %s completion late: actual ready 0 expected 1 (addr %h)", req, a);
      end
      wasempty = cached && qa.size() == 0;
      cyc++;
      if (cyc > 200) begin
        errors++;
        $display("FAIL %s request stuck: actual ready 0 expected 1 (addr %h)", req, a);
        qa.delete(); qd.delete(); qw.delete();
        break;
      end
      @(negedge clk);
    end
    @(negedge clk);
    cpu_valid = 0; cpu_we = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int s = 0; s < 128; s++) begin
      m_lru[s] = 0;
      for (int w = 0; w < 2; w++) begin m_val[w][s] = 0; m_dty[w][s] = 0; m_tag[w][s] = '0; end
    end
    // R10: outputs quiet in reset even with an uncached request pending
    @(negedge clk);
    en_data = 0; cpu_valid = 1; cpu_addr = 32'h0000_0040;
    repeat (2) @(negedge clk);
    #3;
    check("R10", "cpu_ready in reset", cpu_ready, 0);
    check("R10", "mem_valid in reset", mem_valid, 0);
    @(negedge clk);
    cpu_valid = 0; en_data = 1;
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    #3 check("R10", "cpu_ready idle", cpu_ready, 0);

    access(0, 0, 32'h0000_0000, 0, "R10");            // cleared state: miss
    access(0, 0, 32'h0000_0004, 0, "R2");             // same line hit
    access(0, 1, 32'h0000_0008, 32'hDEAD_0008, "R7"); // write hit, dirty
    access(0, 0, 32'h0000_0008, 0, "R7");
    access(0, 0, 32'h0000_1010, 0, "R3");             // way 1 free
    access(0, 0, 32'h0000_001C, 0, "R4");             // way 0 most recent
    access(0, 0, 32'h0000_2000, 0, "R4");             // replaces way 1 (clean)
    access(0, 0, 32'h0000_3000, 0, "R5");             // replaces dirty way 0
    access(0, 0, 32'h0000_0008, 0, "R5");             // written-back word returns
    access(0, 0, 32'h0000_0020, 0, "R6");
    access(0, 0, 32'h0000_003C, 0, "R1");             // same set 1: hit
    access(0, 0, 32'h0000_0040, 0, "R1");             // set 2: miss
    access(0, 1, 32'h5000_0104, 32'h1234_5678, "R7"); // write miss allocates
    access(0, 0, 32'h5000_0104, 0, "R7");
    @(negedge clk) en_data = 0;
    access(0, 0, 32'h5000_0104, 0, "R8");             // bypass reads memory copy
    access(0, 1, 32'h0000_0200, 32'hCAFE_0200, "R8");
    access(1, 0, 32'h5000_0104, 0, "R8");             // instr class still cached
    @(negedge clk) en_data = 1;
    access(0, 0, 32'h5000_0104, 0, "R9");             // still a hit
    access(0, 0, 32'h0000_0200, 0, "R9");             // bypass did not allocate
    @(negedge clk) en_instr = 0;
    access(1, 0, 32'h0000_0200, 0, "R8");
    access(1, 1, 32'h0000_0204, 32'h0BAD_F00D, "R9");
    @(negedge clk) en_instr = 1;
    access(0, 0, 32'h0000_0204, 0, "R9");             // cached copy unaffected

    for (int i = 0; i < 400; i++) begin
      logic [31:0] r, a;
      if (i % 60 == 0) begin
        @(negedge clk);
        en_data  = ((i / 60) % 4) != 2;
        en_instr = ((i / 60) % 4) != 1;
      end
      r = $urandom;
      a = (32'(r[3:2]) << 12) | (32'(r[5:4]) << 5) | (32'(r[8:6]) << 2);
      access(r[9], r[10] && !r[9], a, $urandom, "R4");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule